// File: doc/BRIEF.md
# Strobe Delay-Setting Controller

This block is the digital control loop of a delay-locked loop that sets the delay of incoming data strobes. A phase detector outside the block reports, once per reference cycle, whether the delay line is too short or too long. A saturating counter steps up or down on that report. A signed phase offset is then added to or subtracted from the counter, and the sum is clamped to the range of valid settings. The counter is six bits wide in the slow frequency mode and five bits wide in the other three modes.

An update generator releases the clamped setting to the downstream delay chains once every eight reference cycles, so every chain moves on the same edge. At that edge each strobe also receives its own setting: the full-period value scaled by that strobe's selected phase fraction. A ready flag tells the capture logic when data can be trusted. It rises after a long lock wait following reset, and after a short wait when the reference clock restarts after a stop.

The offset source is fixed by a parameter. It can be a static constant, a dynamic value that is always added, a dynamic value that is always subtracted, or a dynamic value whose sign of application follows a control input.

Top module: `dll_setting_ctrl`

## Requirements
- R1: While `rst_n` is low, `dly_setting`, `strobe_setting`, `upd_pulse` and `ready` are all zero.
- R2: On each rising edge with `step_en` high and `clk_stop` low, the internal counter moves up by one if `step_up` is 1 and down by one if it is 0. Otherwise it holds.
- R3: The counter saturates. Its range is 0..63 in mode 0 (`freq_mode`=0) and 0..31 in modes 1, 2 and 3, and it never wraps. A count above the limit, left over from a mode change, is forced to the limit at the next edge.
- R4: In mode 0 the effective offset is `ofs_in` read as a 7-bit two's-complement value (-64..+63). In the other modes it is `ofs_in[5:0]` read as a 6-bit two's-complement value (-32..+31). With the default variant, `ofs_add`=1 adds the offset to the counter and `ofs_add`=0 subtracts it. The result is clamped to 0..limit.
- R5: While `clk_stop` is low, `upd_pulse` is high for exactly one cycle in every eight. The first pulse follows the 8th rising edge after reset release. While `clk_stop` is high, no pulse occurs and the eight-cycle phase is frozen.
- R6: `dly_setting` and `strobe_setting` change only on the edge that raises `upd_pulse`. On that edge they take the clamped sum computed from the counter and the inputs present at that edge.
- R7: After reset release, `ready` rises on the 256th rising edge with `clk_stop` low.
- R8: `clk_stop` high clears `ready` at the next edge and restarts the wait. Once `clk_stop` drops, `ready` returns after 16 edges if it had been high since reset, and after 256 edges otherwise.
- R9: Strobe s uses the code k = `phase_sel[2s+1:2s]`. In modes 0, 2 and 3 (12 elements of 30 degrees) it receives floor(setting*(k+1)/12). In mode 1 (16 elements of 22.5 degrees) it receives floor(setting*(k+1)/16). Strobe s sits at bits [6s+5:6s].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_mode | input | 2 | Frequency mode: 0 six-bit, 1 fine 16-element, 2 and 3 five-bit 12-element |
| clk_stop | input | 1 | Reference clock is stopped; freezes the loop and drops ready |
| step_en | input | 1 | Phase detector report is valid this cycle |
| step_up | input | 1 | Phase detector direction: 1 lengthen, 0 shorten |
| ofs_in | input | 7 | Dynamic phase offset, two's complement |
| ofs_add | input | 1 | 1 add offset, 0 subtract it |
| phase_sel | input | 4 | Two-bit phase code per strobe |
| upd_pulse | output | 1 | Update enable to the delay chains |
| dly_setting | output | 6 | Released full-period delay setting |
| strobe_setting | output | 12 | Released per-strobe settings, 6 bits each |
| ready | output | 1 | Captured data may be trusted |

## Verification
The bench builds the block with its default parameters: a 6-bit wide counter and a 5-bit narrow counter, an eight-cycle update period, waits of 256 and 16 cycles, two strobes, and the offset whose sign follows `ofs_add`. These values make both counter limits, both offset readings, the narrow-mode reinterpretation of bit 6, and both clamps reachable within a few hundred cycles. The full 256-cycle lock wait is run after each reset, including a cold restart in which the clock stops before lock was ever reached.

// File: rtl/dll_ctrl_pkg.sv
package dll_ctrl_pkg;

   // offset source variants
   localparam int OFS_STATIC = 0;
   localparam int OFS_ADD    = 1;
   localparam int OFS_SUB    = 2;
   localparam int OFS_CTRL   = 3;

   // frequency mode codes
   localparam logic [1:0] MODE_WIDE = 2'd0;
   localparam logic [1:0] MODE_FINE = 2'd1;

   // largest legal setting for a mode
   function automatic int lim_of(logic [1:0] mode, int wide_w, int narrow_w);
      return (mode == MODE_WIDE) ? (1 << wide_w) - 1 : (1 << narrow_w) - 1;
   endfunction

endpackage

// File: rtl/dll_step_counter.sv
module dll_step_counter
   import dll_ctrl_pkg::*;
#(
   parameter int WIDE_W   = 6,
   parameter int NARROW_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              hold,
   input  logic              step_en,
   input  logic              step_up,
   output logic [WIDE_W-1:0] cnt_q
);

   logic [WIDE_W-1:0] lim;
   logic [WIDE_W-1:0] nxt;

   assign lim = WIDE_W'(lim_of(mode, WIDE_W, NARROW_W));

   always_comb begin
      nxt = cnt_q;
      if (!hold && step_en) begin
         if (step_up) nxt = (cnt_q >= lim) ? lim : cnt_q + 1'b1;
         else         nxt = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
      end
      // leftover value from a wider mode is pulled down to the limit
      if (nxt > lim) nxt = lim;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= nxt;
   end

endmodule

// File: rtl/dll_offset_comb.sv
module dll_offset_comb
   import dll_ctrl_pkg::*;
#(
   parameter int WIDE_W     = 6,
   parameter int NARROW_W   = 5,
   parameter int OFS_KIND   = OFS_CTRL,
   parameter int STATIC_OFS = 0
) (
   input  logic [1:0]        mode,
   input  logic [WIDE_W-1:0] cnt,
   input  logic [WIDE_W:0]   ofs_in,
   input  logic              ofs_add,
   output logic [WIDE_W-1:0] comb
);

   localparam int SW = WIDE_W + 3;
   localparam logic [WIDE_W:0] STATIC_RAW = (WIDE_W+1)'(STATIC_OFS);

   logic [WIDE_W:0]   raw;
   logic              add_sel;
   logic [WIDE_W-1:0] lim;
   logic signed [SW-1:0] eff, base, limx, sum;

   generate
      if (OFS_KIND == OFS_STATIC) begin : g_static
         assign raw     = STATIC_RAW;
         assign add_sel = 1'b1;
      end else if (OFS_KIND == OFS_ADD) begin : g_add
         assign raw     = ofs_in;
         assign add_sel = 1'b1;
      end else if (OFS_KIND == OFS_SUB) begin : g_sub
         assign raw     = ofs_in;
         assign add_sel = 1'b0;
      end else begin : g_ctrl
         assign raw     = ofs_in;
         assign add_sel = ofs_add;
      end
   endgenerate

   assign lim  = WIDE_W'(lim_of(mode, WIDE_W, NARROW_W));
   // narrow modes read one bit less of the offset, with its own sign bit
   assign eff  = (mode == MODE_WIDE) ? {{(SW-WIDE_W-1){raw[WIDE_W]}}, raw}
                                     : {{(SW-NARROW_W-1){raw[NARROW_W]}}, raw[NARROW_W:0]};
   assign base = {{(SW-WIDE_W){1'b0}}, cnt};
   assign limx = {{(SW-WIDE_W){1'b0}}, lim};
   assign sum  = add_sel ? base + eff : base - eff;

   always_comb begin
      if (sum[SW-1])       comb = '0;
      else if (sum > limx) comb = lim;
      else                 comb = sum[WIDE_W-1:0];
   end

endmodule

// File: rtl/dll_update_gen.sv
module dll_update_gen
   import dll_ctrl_pkg::*;
#(
   parameter int WIDE_W     = 6,
   parameter int UPD_PERIOD = 8,
   parameter int N_STROBE   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       hold,
   input  logic [1:0]                 mode,
   input  logic [WIDE_W-1:0]          comb,
   input  logic [2*N_STROBE-1:0]      phase_sel,
   output logic                       upd_q,
   output logic [WIDE_W-1:0]          set_q,
   output logic [N_STROBE*WIDE_W-1:0] str_q
);

   localparam int DIV_W = $clog2(UPD_PERIOD);
   localparam int PW    = WIDE_W + 3;

   logic [DIV_W-1:0] div_q;
   logic             fire;

   assign fire = !hold && (div_q == DIV_W'(UPD_PERIOD - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         upd_q <= 1'b0;
         set_q <= '0;
      end else begin
         upd_q <= fire;
         if (!hold) div_q <= fire ? '0 : div_q + 1'b1;
         if (fire)  set_q <= comb;
      end
   end

   for (genvar s = 0; s < N_STROBE; s++) begin : g_str
      logic [1:0]        code;
      logic [PW-1:0]     prod;
      logic [PW-1:0]     quo;
      logic [WIDE_W-1:0] sq;

      assign code = phase_sel[2*s +: 2];
      assign prod = PW'(comb) * PW'({1'b0, code} + 3'd1);
      assign quo  = (mode == MODE_FINE) ? (prod >> 4) : prod / PW'(12);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    sq <= '0;
         else if (fire) sq <= WIDE_W'(quo);
      end

      assign str_q[s*WIDE_W +: WIDE_W] = sq;
   end

endmodule

// File: rtl/dll_ready_timer.sv
module dll_ready_timer #(
   parameter int LOCK_CYCLES    = 256,
   parameter int RESTART_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stop,
   output logic ready_q
);

   localparam int CW = $clog2(LOCK_CYCLES + 1);

   logic [CW-1:0] wait_q;
   logic [CW-1:0] target;
   logic          warm_q;

   assign target = warm_q ? CW'(RESTART_CYCLES - 1) : CW'(LOCK_CYCLES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q  <= '0;
         ready_q <= 1'b0;
         warm_q  <= 1'b0;
      end else if (stop) begin
         wait_q  <= '0;
         ready_q <= 1'b0;
      end else if (!ready_q) begin
         if (wait_q == target) begin
            ready_q <= 1'b1;
            warm_q  <= 1'b1;
            wait_q  <= '0;
         end else begin
            wait_q  <= wait_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/dll_setting_ctrl.sv
module dll_setting_ctrl
   import dll_ctrl_pkg::*;
#(
   parameter int WIDE_W         = 6,
   parameter int NARROW_W       = 5,
   parameter int UPD_PERIOD     = 8,
   parameter int LOCK_CYCLES    = 256,
   parameter int RESTART_CYCLES = 16,
   parameter int N_STROBE       = 2,
   parameter int OFS_KIND       = OFS_CTRL,
   parameter int STATIC_OFS     = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [1:0]                 freq_mode,
   input  logic                       clk_stop,
   input  logic                       step_en,
   input  logic                       step_up,
   input  logic [WIDE_W:0]            ofs_in,
   input  logic                       ofs_add,
   input  logic [2*N_STROBE-1:0]      phase_sel,
   output logic                       upd_pulse,
   output logic [WIDE_W-1:0]          dly_setting,
   output logic [N_STROBE*WIDE_W-1:0] strobe_setting,
   output logic                       ready
);

   if (NARROW_W >= WIDE_W || NARROW_W < 2) begin : g_bad_width
      $error("narrow width must be below wide width and at least 2");
   end
   if (OFS_KIND < OFS_STATIC || OFS_KIND > OFS_CTRL) begin : g_bad_kind
      $error("unknown offset variant");
   end
   if (STATIC_OFS < -(1 << WIDE_W) || STATIC_OFS >= (1 << WIDE_W)) begin : g_bad_ofs
      $error("static offset outside the two's-complement range");
   end
   if (UPD_PERIOD < 2) begin : g_bad_period
      $error("update period must be at least 2");
   end
   if (RESTART_CYCLES < 1 || RESTART_CYCLES > LOCK_CYCLES) begin : g_bad_wait
      $error("restart wait must lie in 1..lock wait");
   end
   if (N_STROBE < 1) begin : g_bad_str
      $error("at least one strobe is needed");
   end

   logic [WIDE_W-1:0] cnt_q;
   logic [WIDE_W-1:0] comb;

   dll_step_counter #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .mode(freq_mode), .hold(clk_stop),
      .step_en(step_en), .step_up(step_up), .cnt_q(cnt_q)
   );

   dll_offset_comb #(
      .WIDE_W(WIDE_W), .NARROW_W(NARROW_W),
      .OFS_KIND(OFS_KIND), .STATIC_OFS(STATIC_OFS)
   ) u_ofs (
      .mode(freq_mode), .cnt(cnt_q), .ofs_in(ofs_in),
      .ofs_add(ofs_add), .comb(comb)
   );

   dll_update_gen #(.WIDE_W(WIDE_W), .UPD_PERIOD(UPD_PERIOD), .N_STROBE(N_STROBE)) u_upd (
      .clk(clk), .rst_n(rst_n), .hold(clk_stop), .mode(freq_mode),
      .comb(comb), .phase_sel(phase_sel), .upd_q(upd_pulse),
      .set_q(dly_setting), .str_q(strobe_setting)
   );

   dll_ready_timer #(.LOCK_CYCLES(LOCK_CYCLES), .RESTART_CYCLES(RESTART_CYCLES)) u_rdy (
      .clk(clk), .rst_n(rst_n), .stop(clk_stop), .ready_q(ready)
   );

endmodule

// File: rtl/dll_setting_ctrl_chk.sv
module dll_setting_ctrl_chk
   import dll_ctrl_pkg::*;
#(
   parameter int WIDE_W      = 6,
   parameter int NARROW_W    = 5,
   parameter int N_STROBE    = 2,
   parameter int LOCK_CYCLES = 256
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [1:0]                 freq_mode,
   input logic                       clk_stop,
   input logic                       step_en,
   input logic [WIDE_W-1:0]          cnt_q,
   input logic                       upd_pulse,
   input logic [WIDE_W-1:0]          dly_setting,
   input logic [N_STROBE*WIDE_W-1:0] strobe_setting,
   input logic                       ready
);

   logic [WIDE_W-1:0] lim;
   int                since;

   assign lim = WIDE_W'(lim_of(freq_mode, WIDE_W, NARROW_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since <= 0;
      else if (since < LOCK_CYCLES) since <= since + 1;
   end

   // R2: no report, or clock stopped, leaves an in-range count unchanged
   a_r2_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
      ((!step_en || clk_stop) && cnt_q <= lim) |=> $stable(cnt_q));

   // R3: with the mode steady the count stays within the mode's range
   a_r3_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(freq_mode) |-> cnt_q <= lim);

   // R5: a pulse lasts one cycle
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      upd_pulse |=> !upd_pulse);

   // R5: no pulse released from a stopped clock
   a_r5_no_pulse_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      upd_pulse |-> !$past(clk_stop));

   // R6: released values move only with the pulse
   a_r6_setting_held: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_pulse |-> ($stable(dly_setting) && $stable(strobe_setting)));

   // R7: ready never precedes the lock wait
   a_r7_lock_wait: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> since >= LOCK_CYCLES);

   // R8: a clock stop drops ready
   a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      clk_stop |=> !ready);

endmodule

bind dll_setting_ctrl dll_setting_ctrl_chk #(
   .WIDE_W(WIDE_W), .NARROW_W(NARROW_W),
   .N_STROBE(N_STROBE), .LOCK_CYCLES(LOCK_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .freq_mode(freq_mode), .clk_stop(clk_stop),
   .step_en(step_en), .cnt_q(cnt_q), .upd_pulse(upd_pulse),
   .dly_setting(dly_setting), .strobe_setting(strobe_setting), .ready(ready)
);

// File: tb/dll_setting_ctrl_test.sv
`timescale 1ns/1ps
module dll_setting_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] freq_mode;
   logic       clk_stop, step_en, step_up, ofs_add;
   logic [6:0] ofs_in;
   logic [3:0] phase_sel;
   logic       upd_pulse, ready;
   logic [5:0] dly_setting;
   logic [11:0] strobe_setting;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 0;

   always #2 clk = ~clk;   // 250 MHz

   dll_setting_ctrl uut (
      .clk(clk), .rst_n(rst_n), .freq_mode(freq_mode), .clk_stop(clk_stop),
      .step_en(step_en), .step_up(step_up), .ofs_in(ofs_in), .ofs_add(ofs_add),
      .phase_sel(phase_sel), .upd_pulse(upd_pulse), .dly_setting(dly_setting),
      .strobe_setting(strobe_setting), .ready(ready)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // ---------------- behavioural reference ----------------
   int m_cnt, m_div, m_set, m_wait;
   int m_str [2];
   bit m_upd, m_rdy, m_warm;

   function automatic int limit(int m);
      return (m == 0) ? 63 : 31;
   endfunction

   function automatic int offset_val(int m, logic [6:0] o);
      if (m == 0) return int'($signed(o));
      return int'($signed(o[5:0]));
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_div = 0; m_set = 0; m_wait = 0;
         m_str[0] = 0; m_str[1] = 0;
         m_upd = 0; m_rdy = 0; m_warm = 0;
      end else begin
         int lim, sum, den, n;
         lim = limit(int'(freq_mode));
         sum = ofs_add ? m_cnt + offset_val(int'(freq_mode), ofs_in)
                       : m_cnt - offset_val(int'(freq_mode), ofs_in);
         if (sum < 0) sum = 0;
         if (sum > lim) sum = lim;
         den = (freq_mode == 2'd1) ? 16 : 12;
         if (!clk_stop) begin
            m_upd = (m_div == 7);
            m_div = (m_div + 1) % 8;
            if (m_upd) begin
               m_set = sum;
               for (int s = 0; s < 2; s++)
                  m_str[s] = (sum * (int'(phase_sel[2*s +: 2]) + 1)) / den;
            end
         end else m_upd = 0;
         if (clk_stop) begin
            m_wait = 0; m_rdy = 0;
         end else if (!m_rdy) begin
            if (m_wait == (m_warm ? 15 : 255)) begin
               m_rdy = 1; m_warm = 1; m_wait = 0;
            end else m_wait++;
         end
         n = m_cnt;
         if (!clk_stop && step_en) n = step_up ? n + 1 : n - 1;
         if (n < 0) n = 0;
         if (n > lim) n = lim;
         m_cnt = n;
      end
   end

   // every-clock comparison against the reference
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         check("R6 dly_setting vs model", int'(dly_setting), m_set);
         check("R5 upd_pulse vs model", int'(upd_pulse), int'(m_upd));
         check("R7 ready vs model", int'(ready), int'(m_rdy));
         check("R9 strobe0 vs model", int'(strobe_setting[5:0]), m_str[0]);
         check("R9 strobe1 vs model", int'(strobe_setting[11:6]), m_str[1]);
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected<=20000", cyc);
         finish_run();
      end
   end

   task automatic wait_upd();
      int guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (!upd_pulse && guard < 40);
   endtask

   initial begin
      rst_n = 1'b0;
      freq_mode = 2'd0; clk_stop = 1'b0; step_en = 1'b0; step_up = 1'b1;
      ofs_in = 7'd0; ofs_add = 1'b1; phase_sel = {2'd3, 2'd2};
      repeat (3) @(negedge clk);
      check("R1 reset setting", int'(dly_setting), 0);
      check("R1 reset strobes", int'(strobe_setting), 0);
      check("R1 reset pulse", int'(upd_pulse), 0);
      check("R1 reset ready", int'(ready), 0);

      // ramp up in the wide mode during the lock wait
      rst_n = 1'b1; step_en = 1'b1; step_up = 1'b1;
      repeat (255) @(negedge clk);
      check("R7 not ready at 255", int'(ready), 0);
      check("R5 no pulse at 255", int'(upd_pulse), 0);
      @(negedge clk);
      check("R7 ready at 256", int'(ready), 1);
      check("R5 pulse at 256", int'(upd_pulse), 1);
      check("R3 saturates at 63", int'(dly_setting), 63);
      check("R9 code2 wide 63*3/12", int'(strobe_setting[5:0]), 15);
      check("R9 code3 wide 63*4/12", int'(strobe_setting[11:6]), 21);

      // offsets in mode 0
      ofs_in = 7'h76; ofs_add = 1'b1; wait_upd();
      check("R4 add -10", int'(dly_setting), 53);
      ofs_add = 1'b0; wait_upd();
      check("R4 subtract -10 clamps high", int'(dly_setting), 63);
      ofs_in = 7'd20; wait_upd();
      check("R4 subtract 20", int'(dly_setting), 43);
      ofs_in = 7'h40; ofs_add = 1'b1; wait_upd();
      check("R4 add -64 clamps low", int'(dly_setting), 0);

      // narrow mode: bit 6 ignored, low six bits signed
      step_en = 1'b0; freq_mode = 2'd1; ofs_in = 7'h3F; ofs_add = 1'b1;
      wait_upd(); wait_upd();
      check("R4 narrow offset -1", int'(dly_setting), 30);
      check("R9 code2 fine 30*3/16", int'(strobe_setting[5:0]), 5);
      check("R9 code3 fine 30*4/16", int'(strobe_setting[11:6]), 7);

      // single steps down
      ofs_in = 7'd0; step_en = 1'b1; step_up = 1'b0;
      repeat (5) @(negedge clk);
      step_en = 1'b0; wait_upd(); wait_upd();
      check("R2 five steps down from 31", int'(dly_setting), 26);

      // floor saturation
      step_en = 1'b1; repeat (40) @(negedge clk);
      ofs_in = 7'd5; ofs_add = 1'b0; step_en = 1'b0;
      wait_upd(); wait_upd();
      check("R3 floor at 0", int'(dly_setting), 0);

      // clock stop and warm restart
      clk_stop = 1'b1; step_en = 1'b1; step_up = 1'b1;
      @(negedge clk);
      check("R8 stop clears ready", int'(ready), 0);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         check("R5 no pulse while stopped", int'(upd_pulse), 0);
      end
      clk_stop = 1'b0; step_en = 1'b0;
      repeat (15) @(negedge clk);
      check("R8 warm not ready at 15", int'(ready), 0);
      @(negedge clk);
      check("R8 warm ready at 16", int'(ready), 1);

      // other modes and phase codes under the model
      ofs_in = 7'd3; ofs_add = 1'b1; phase_sel = {2'd0, 2'd1};
      freq_mode = 2'd2; step_en = 1'b1; step_up = 1'b1;
      repeat (60) @(negedge clk);
      freq_mode = 2'd3; step_up = 1'b0; repeat (20) @(negedge clk);
      freq_mode = 2'd0; step_up = 1'b1; phase_sel = {2'd2, 2'd3};
      repeat (80) @(negedge clk);
      freq_mode = 2'd1; repeat (30) @(negedge clk);

      // reset again, stop before lock: cold wait applies
      rst_n = 1'b0; repeat (2) @(negedge clk);
      rst_n = 1'b1; repeat (50) @(negedge clk);
      clk_stop = 1'b1; repeat (5) @(negedge clk);
      clk_stop = 1'b0;
      repeat (255) @(negedge clk);
      check("R8 cold not ready at 255", int'(ready), 0);
      @(negedge clk);
      check("R8 cold ready at 256", int'(ready), 1);
      repeat (10) @(negedge clk);

      finish_run();
   end

endmodule